// File: doc/BRIEF.md
# Packed Sign-Bit Test Flag Unit

This block takes two packed vector operands of up to 256 bits and derives two status flags from the sign bits of their elements alone. A zero flag reports whether no element has its sign bit set in both operands at once; a carry flag reports whether no element has its sign bit set in the second operand while it is clear in the first. All other bits of the operands are disregarded, and no floating-point arithmetic takes place.

The element size is chosen per request: 32-bit elements place a sign bit at positions 31 and 63 of every 64-bit chunk, and 64-bit elements use only position 63. A length input selects either the low 128 bits (two chunks) or the whole 256 bits (four chunks). The flag logic itself is combinational. The six-flag result is captured into an output register on the clock edge that samples a valid strobe, and a done pulse accompanies it.

Top module: `sign_test_flags`

## Requirements
- R1: After synchronous reset, `flags_o` is 6'b000000 and `done_o` is 0.
- R2: `done_o` is high for exactly the one cycle that follows each cycle with `valid_i` high, and is low otherwise.
- R3: `flags_o` is packed as {OF,SF,ZF,AF,PF,CF} with OF at bit 5 and CF at bit 0. OF, SF, AF and PF (bits 5, 4, 2, 1) are always 0.
- R4: ZF (bit 3) is 1 unless some scanned sign position is 1 in both `src_a_i` and `src_b_i`.
- R5: CF (bit 0) is 1 unless some scanned sign position is 1 in `src_b_i` and 0 in `src_a_i`.
- R6: With `elem64_i`=0 (32-bit elements) the scanned sign positions within each 64-bit chunk k are bits 64k+31 and 64k+63. With `elem64_i`=1 (64-bit elements) only bit 64k+63 is scanned, and bit 64k+31 has no effect.
- R7: With `wide_i`=0 only chunks 0 and 1 (bits 127:0) are scanned, and bits 255:128 of both operands have no effect. With `wide_i`=1 chunks 0 to 3 are scanned.
- R8: Bits that are not scanned sign positions never change `flags_o`.
- R9: `flags_o` holds its value in cycles that follow a cycle with `valid_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe; operands and modes sampled when high |
| elem64_i | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| wide_i | input | 1 | 0: 128-bit length, 1: 256-bit length |
| src_a_i | input | 256 | First operand |
| src_b_i | input | 256 | Second operand |
| flags_o | output | 6 | Registered {OF,SF,ZF,AF,PF,CF} |
| done_o | output | 1 | One-cycle pulse with a new result |

## Verification
The bench builds the block with its defaults: 64-bit chunks, four chunks at full length and two at short length. That makes every sign position of both element sizes reachable, including the upper half that the short length must mask. A sign hit placed in the top chunk while the short length is selected can therefore be compared against the same hit with the full length selected. The 32-bit position (bit 31) in 64-bit element mode can be checked the same way.

// File: rtl/stf_pkg.sv
package stf_pkg;
  localparam int FLAG_W = 6;
  localparam int OF_BIT = 5;
  localparam int SF_BIT = 4;
  localparam int ZF_BIT = 3;
  localparam int AF_BIT = 2;
  localparam int PF_BIT = 1;
  localparam int CF_BIT = 0;

  typedef struct packed {
    logic zero_hit;
    logic carry_hit;
  } hit_t;
endpackage

// File: rtl/stf_chunk_scan.sv
module stf_chunk_scan #(
  parameter int CHUNK_W = 64
) (
  input  logic               elem64,
  input  logic               enable,
  input  logic [CHUNK_W-1:0] a,
  input  logic [CHUNK_W-1:0] b,
  output stf_pkg::hit_t      hit
);
  localparam int HI_SIGN = CHUNK_W - 1;
  localparam int LO_SIGN = CHUNK_W / 2 - 1;

  logic [CHUNK_W-1:0] sign_mask;
  logic [CHUNK_W-1:0] both_set;
  logic [CHUNK_W-1:0] b_only;

  always_comb begin
    sign_mask = '0;
    sign_mask[HI_SIGN] = enable;
    sign_mask[LO_SIGN] = enable & ~elem64;
    both_set = a & b & sign_mask;
    b_only   = ~a & b & sign_mask;
    hit.zero_hit  = |both_set;
    hit.carry_hit = |b_only;
  end
endmodule

// File: rtl/stf_flag_reduce.sv
module stf_flag_reduce #(
  parameter int NCHUNK = 4
) (
  input  stf_pkg::hit_t [NCHUNK-1:0] hits,
  output logic [stf_pkg::FLAG_W-1:0] flags
);
  logic any_zero_hit;
  logic any_carry_hit;

  always_comb begin
    any_zero_hit  = 1'b0;
    any_carry_hit = 1'b0;
    for (int k = 0; k < NCHUNK; k++) begin
      any_zero_hit  = any_zero_hit  | hits[k].zero_hit;
      any_carry_hit = any_carry_hit | hits[k].carry_hit;
    end
    flags = '0;
    flags[stf_pkg::ZF_BIT] = ~any_zero_hit;
    flags[stf_pkg::CF_BIT] = ~any_carry_hit;
  end
endmodule

// File: rtl/sign_test_flags.sv
module sign_test_flags #(
  parameter int VEC_W   = 256,
  parameter int CHUNK_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             elem64_i,
  input  logic             wide_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  output logic [5:0]       flags_o,
  output logic             done_o
);
  import stf_pkg::*;

  localparam int NCHUNK   = VEC_W / CHUNK_W;
  localparam int NARROW_N = NCHUNK / 2;

  hit_t [NCHUNK-1:0]  hits;
  logic [FLAG_W-1:0]  flags_next;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    logic chunk_en;
    if (k < NARROW_N) begin : g_low
      assign chunk_en = 1'b1;
    end else begin : g_high
      assign chunk_en = wide_i;
    end
    stf_chunk_scan #(.CHUNK_W(CHUNK_W)) u_scan (
      .elem64 (elem64_i),
      .enable (chunk_en),
      .a      (src_a_i[k*CHUNK_W +: CHUNK_W]),
      .b      (src_b_i[k*CHUNK_W +: CHUNK_W]),
      .hit    (hits[k])
    );
  end

  stf_flag_reduce #(.NCHUNK(NCHUNK)) u_reduce (
    .hits  (hits),
    .flags (flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) flags_o <= flags_next;
    end
  end

  // R3: the four unused flags never leave zero
  a_r3_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (flags_o[OF_BIT] | flags_o[SF_BIT] | flags_o[AF_BIT] | flags_o[PF_BIT]) == 1'b0);

  // R2: done follows valid by one cycle
  a_r2_done_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);
  a_r2_done_only: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !done_o);

  // R9: result held between requests
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(flags_o));

  // R4: a common sign in chunk 0 high position clears ZF
  a_r4_zf_clear: assert property (@(posedge clk) disable iff (rst)
    (valid_i && src_a_i[CHUNK_W-1] && src_b_i[CHUNK_W-1]) |=> !flags_o[ZF_BIT]);

  // R5: a b-only sign in chunk 0 high position clears CF
  a_r5_cf_clear: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !src_a_i[CHUNK_W-1] && src_b_i[CHUNK_W-1]) |=> !flags_o[CF_BIT]);

  // R5: zero second operand leaves both flags set
  a_r5_zero_b: assert property (@(posedge clk) disable iff (rst)
    (valid_i && src_b_i == '0) |=> (flags_o[ZF_BIT] && flags_o[CF_BIT]));
endmodule

// File: tb/sim_sign_test_flags.sv
module sim_sign_test_flags;
  localparam int W = 256;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst;
  logic valid_i, elem64_i, wide_i;
  logic [W-1:0] src_a_i, src_b_i;
  logic [5:0] flags_o;
  logic done_o;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sign_test_flags u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .elem64_i(elem64_i),
    .wide_i(wide_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .flags_o(flags_o), .done_o(done_o)
  );

  // vector: {elem64, wide, a bit index, b bit index, a_en, b_en, expected flags}
  // flags packing {OF,SF,ZF,AF,PF,CF}: ZF=6'b001000, CF=6'b000001
  typedef struct packed {
    logic       e64;
    logic       wd;
    logic [7:0] abit;
    logic [7:0] bbit;
    logic       aen;
    logic       ben;
    logic [5:0] exp;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 8'd63,  8'd63,  1'b1, 1'b1, 6'b000001}, // R4 both set at 63
    '{1'b0, 1'b1, 8'd0,   8'd31,  1'b0, 1'b1, 6'b001000}, // R5 b only at 31
    '{1'b1, 1'b1, 8'd31,  8'd31,  1'b1, 1'b1, 6'b001001}, // R6 bit31 ignored in 64-bit mode
    '{1'b1, 1'b1, 8'd0,   8'd95,  1'b0, 1'b1, 6'b001001}, // R6 bit95 ignored in 64-bit mode
    '{1'b0, 1'b1, 8'd0,   8'd95,  1'b0, 1'b1, 6'b001000}, // R6 bit95 used in 32-bit mode
    '{1'b0, 1'b0, 8'd255, 8'd255, 1'b1, 1'b1, 6'b001001}, // R7 upper ignored narrow
    '{1'b0, 1'b1, 8'd255, 8'd255, 1'b1, 1'b1, 6'b000001}, // R7 upper used wide
    '{1'b1, 1'b0, 8'd0,   8'd191, 1'b0, 1'b1, 6'b001001}, // R7 narrow 64-bit
    '{1'b1, 1'b1, 8'd0,   8'd191, 1'b0, 1'b1, 6'b001000}, // R7 wide 64-bit
    '{1'b0, 1'b1, 8'd30,  8'd30,  1'b1, 1'b1, 6'b001001}, // R8 non-sign bit
    '{1'b0, 1'b1, 8'd127, 8'd127, 1'b1, 1'b1, 6'b000001}, // R4 chunk1
    '{1'b0, 1'b1, 8'd159, 8'd0,   1'b1, 1'b0, 6'b001001}  // R5 a only, b zero
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic e64, input logic wd, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    valid_i = 1'b1; elem64_i = e64; wide_i = wd; src_a_i = a; src_b_i = b;
    @(negedge clk);
    valid_i = 1'b0; src_a_i = '1; src_b_i = '1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; elem64_i = 1'b0; wide_i = 1'b0;
    src_a_i = '0; src_b_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", {done_o, flags_o}, 7'b0_000000);

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] a, b;
      a = '0; b = '0;
      if (VT[i].aen) a[VT[i].abit] = 1'b1;
      if (VT[i].ben) b[VT[i].bbit] = 1'b1;
      apply(VT[i].e64, VT[i].wd, a, b);
      check("R3/R4/R5/R6/R7/R8 vector", {done_o, flags_o}, {1'b1, VT[i].exp});
    end

    // R2 and R9: no strobe -> done low, flags held
    @(negedge clk);
    check("R2 done drops", {done_o, 6'b0}, 7'b0);
    check("R9 hold", {1'b0, flags_o}, {1'b0, VT[NV-1].exp});

    // R8: all non-sign bits set, signs clear
    begin
      logic [W-1:0] m;
      m = '1;
      for (int k = 0; k < 4; k++) begin
        m[64*k+63] = 1'b0; m[64*k+31] = 1'b0;
      end
      apply(1'b0, 1'b1, m, m);
      check("R8 noise only", {done_o, flags_o}, 7'b1_001001);
    end

    // R4 R5: both flags cleared together, all ones in b, a alternating
    apply(1'b0, 1'b1, {4{64'h0000_0000_8000_0000}}, '1);
    check("R4 R5 both clear", {done_o, flags_o}, 7'b1_000000);

    // R1 again: reset mid-stream
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 re-reset", {done_o, flags_o}, 7'b0_000000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule